// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector memory instruction into a stream of element addresses, one per cycle, for a memory built from several word-interleaved banks. A start pulse captures the access mode, a base word address, a scalar stride and the requested element count. The block then steps through the elements. It adds the element number to the base (unit stride), adds a running multiple of the stride (constant stride), or adds an index word that the surrounding logic supplies for the element currently on `elem_idx` (indexed gather or scatter). Gather loads and scatter stores use the same index stream.

Every address is split into a bank number and a word offset inside that bank. Each bank stays occupied for a fixed number of cycles after it is accessed. When the next element would land on an occupied bank, the element is held and `conflict` is raised until the bank becomes free. An external `stall` also freezes the stream. The data path and the memory banks themselves lie outside this block.

Top module: `vec_agen`

## Requirements
- R1: With mode 0 (unit stride), element i is issued at address base + i.
- R2: With mode 1 (constant stride), element i is issued at address base + i*stride, computed modulo 2^ADDR_W, so a negative two's-complement stride walks downward.
- R3: With mode 2 (indexed), element i is issued at address base + idx_val. Here idx_val is the value presented while `elem_idx` equals i.
- R4: Each issued address drives `bank` = address mod NUM_BANKS (the low 3 bits for 8 banks) and `offset` = address / NUM_BANKS.
- R5: After a bank is accessed in cycle t, it is not accessed again before cycle t+BUSY_CYC (8 by default). While the current element waits for its bank, `addr_valid` is low and `conflict` is high.
- R6: In unit-stride mode with NUM_BANKS >= BUSY_CYC and free banks at the start, one element is issued in every cycle, beginning the cycle after the start pulse is taken.
- R7: The number of elements issued equals the requested length, capped at 64. A length of 0 issues nothing and leaves `busy` low.
- R8: `last` is high only in the cycle that issues the final element, and `busy` falls right after it.
- R9: While `stall` is high, no element is issued and `elem_idx` holds. The held element is issued unchanged afterwards.
- R10: A start pulse that arrives while `busy` is high is ignored, and the running sequence keeps its captured mode, base and stride.
- R11: After reset, `addr_valid`, `busy` and `conflict` are low and all banks are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new vector access when idle |
| mode | input | 2 | 0 unit stride, 1 constant stride, 2 indexed |
| base | input | ADDR_W | Base word address |
| stride | input | ADDR_W | Stride in words for mode 1 |
| vlen | input | 8 | Requested element count (capped at 64) |
| idx_val | input | ADDR_W | Index word for the element on elem_idx |
| stall | input | 1 | Hold the stream |
| addr_valid | output | 1 | An element address is issued this cycle |
| addr | output | ADDR_W | Word address of the current element |
| bank | output | 3 | Bank number of addr |
| offset | output | ADDR_W-3 | Word offset inside the bank |
| elem_idx | output | 7 | Number of the current element |
| last | output | 1 | Final element is issued this cycle |
| conflict | output | 1 | Current element waits for a busy bank |
| busy | output | 1 | A sequence is in progress |

## Verification
The stream is exercised with several stride patterns. A unit stride and a stride of 3 both reach all eight banks and must run at full rate. Strides of 2, 4 and 8 revisit banks early, so they expose the exact wait length and the `conflict` timing. A negative stride checks the wrapping arithmetic. A scattered index table exercises the indexed path and gives irregular bank reuse. A request for 70 elements checks the cap, and a length of 0 checks the empty case. A stall window, and a start pulse sent in the middle of a run, show that the held element and the captured parameters stay intact.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
  typedef enum logic [1:0] {
    AG_UNIT   = 2'd0,
    AG_STRIDE = 2'd1,
    AG_INDEX  = 2'd2,
    AG_RSVD   = 2'd3
  } ag_mode_e;
endpackage

// File: rtl/vagen_addr.sv
module vagen_addr #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int OFF_W    = ADDR_W - BANK_W
) (
  input  vagen_pkg::ag_mode_e mode,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   acc,
  input  logic [CNT_W-1:0]    elem,
  input  logic [ADDR_W-1:0]   idx_val,
  output logic [ADDR_W-1:0]   addr,
  output logic [BANK_W-1:0]   bank,
  output logic [OFF_W-1:0]    offset
);
  import vagen_pkg::*;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return BANK_W'(a % NUM_BANKS);
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return OFF_W'(a / NUM_BANKS);
  endfunction

  always_comb begin
    unique case (mode)
      AG_STRIDE: addr = acc;
      AG_INDEX:  addr = base + idx_val;
      default:   addr = base + ADDR_W'(elem);
    endcase
    bank   = bank_of(addr);
    offset = offset_of(addr);
  end
endmodule

// File: rtl/vagen_banks.sv
module vagen_banks #(
  parameter int NUM_BANKS = 8,
  parameter int BUSY_CYC  = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CW       = $clog2(BUSY_CYC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_bank,
  input  logic [BANK_W-1:0] query_bank,
  output logic              query_busy
);
  logic [NUM_BANKS-1:0] busy_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] left;
    always_ff @(posedge clk) begin
      if (!rst_n)
        left <= '0;
      else if (hit && hit_bank == BANK_W'(b))
        left <= CW'(BUSY_CYC - 1);
      else if (left != '0)
        left <= left - 1'b1;
    end
    assign busy_vec[b] = (left != '0);
  end

  assign query_busy = busy_vec[query_bank];
endmodule

// File: rtl/vec_agen.sv
module vec_agen #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int BUSY_CYC  = 8,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int OFF_W    = ADDR_W - BANK_W,
  localparam int CNT_W    = $clog2(MAX_VL + 1),
  localparam int VLEN_W   = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [VLEN_W-1:0] vlen,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              stall,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  offset,
  output logic [CNT_W-1:0]  elem_idx,
  output logic              last,
  output logic              conflict,
  output logic              busy
);
  import vagen_pkg::*;

  localparam logic [VLEN_W-1:0] VL_CAP = VLEN_W'(MAX_VL);

  logic              active;
  ag_mode_e          mode_r;
  logic [ADDR_W-1:0] base_r, stride_r, acc_r;
  logic [CNT_W-1:0]  cnt_r, vl_r;
  logic [VLEN_W-1:0] vl_sat;
  logic              bank_busy, fire, final_elem, take_start;

  assign vl_sat     = (vlen > VL_CAP) ? VL_CAP : vlen;
  assign take_start = start && !active;
  assign conflict   = active && bank_busy;
  assign fire       = active && !stall && !bank_busy;
  assign final_elem = (cnt_r + 1'b1) == vl_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      mode_r   <= AG_UNIT;
      base_r   <= '0;
      stride_r <= '0;
      acc_r    <= '0;
      cnt_r    <= '0;
      vl_r     <= '0;
    end else if (take_start) begin
      active   <= (vl_sat != '0);
      mode_r   <= ag_mode_e'(mode);
      base_r   <= base;
      stride_r <= stride;
      acc_r    <= base;
      cnt_r    <= '0;
      vl_r     <= CNT_W'(vl_sat);
    end else if (fire) begin
      acc_r <= acc_r + stride_r;
      cnt_r <= cnt_r + 1'b1;
      if (final_elem) active <= 1'b0;
    end
  end

  vagen_addr #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
  ) u_addr (
    .mode(mode_r), .base(base_r), .acc(acc_r), .elem(cnt_r),
    .idx_val(idx_val), .addr(addr), .bank(bank), .offset(offset)
  );

  vagen_banks #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .hit(fire), .hit_bank(bank),
    .query_bank(bank), .query_busy(bank_busy)
  );

  assign addr_valid = fire;
  assign last       = fire && final_elem;
  assign elem_idx   = cnt_r;
  assign busy       = active;
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int BUSY_CYC  = 8,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int OFF_W    = ADDR_W - BANK_W,
  localparam int CNT_W    = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic [OFF_W-1:0]  offset,
  input logic [CNT_W-1:0]  elem_idx,
  input logic              last,
  input logic              conflict,
  input logic              busy
);
  // R8: final flag only accompanies an issued element
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> addr_valid);

  // R8: sequence ends right after the final element
  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  // R9: nothing issued while stalled, element held
  a_r9_no_issue_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !addr_valid);
  a_r9_hold_element: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall) |=> $stable(elem_idx));

  // R5: a waiting element is never issued
  a_r5_conflict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !addr_valid);

  // R5: consecutive issues never reuse a bank when banks stay busy
  a_r5_no_back_to_back_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (BUSY_CYC > 1 && addr_valid && $past(addr_valid)) |-> bank != $past(bank));

  // R4: bank and offset recompose the address
  a_r4_split_recompose: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> {offset, bank} == addr);

  // R7: elements are only issued during a sequence
  a_r7_valid_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> busy);
endmodule

bind vec_agen vec_agen_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC), .MAX_VL(MAX_VL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .addr_valid(addr_valid),
  .addr(addr), .bank(bank), .offset(offset), .elem_idx(elem_idx),
  .last(last), .conflict(conflict), .busy(busy)
);

// File: tb/vec_agen_bench.sv
`timescale 1ns/1ps
module vec_agen_bench;
  localparam int AW = 32;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode_in = 2'd0;
  logic [AW-1:0] base_in = '0;
  logic [AW-1:0] stride_in = '0;
  logic [7:0]    vlen_in = '0;
  logic [AW-1:0] idx_val;
  logic          stall_in = 1'b0;
  logic          addr_valid, last, conflict, busy;
  logic [AW-1:0] addr;
  logic [2:0]    bank;
  logic [AW-4:0] offset;
  logic [6:0]    elem_idx;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] idx_tab [64];

  always #10 clk = ~clk;

  vec_agen u_vec_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_in), .base(base_in),
    .stride(stride_in), .vlen(vlen_in), .idx_val(idx_val), .stall(stall_in),
    .addr_valid(addr_valid), .addr(addr), .bank(bank), .offset(offset),
    .elem_idx(elem_idx), .last(last), .conflict(conflict), .busy(busy)
  );

  assign idx_val = idx_tab[elem_idx[5:0]];

  // {mode, base, stride, length}
  localparam logic [73:0] VEC [8] = '{
    {2'd0, 32'd100,        32'd1,          8'd10},
    {2'd1, 32'd5,          32'd3,          8'd12},
    {2'd1, 32'd0,          32'd2,          8'd9},
    {2'd1, 32'd7,          32'd4,          8'd6},
    {2'd2, 32'd1000,       32'd0,          8'd16},
    {2'd0, 32'd16,         32'd1,          8'd70},
    {2'd1, 32'd50,         32'hFFFF_FFFD,  8'd5},
    {2'd1, 32'd3,          32'd8,          8'd3}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int md, input logic [AW-1:0] b,
                                             input logic [AW-1:0] s, input int n);
    if (md == 1) return b + s * AW'(n);
    if (md == 2) return b + idx_tab[n];
    return b + AW'(n);
  endfunction

  task automatic run_vec(input int md, input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int vl, input int sf, input int st, input int poke);
    int nexp, n, cyc, prev, t, lu;
    int lastuse [8];
    logic [AW-1:0] ea;
    string at, tt;
    at = (md == 0) ? "R1" : (md == 1) ? "R2" : "R3";
    tt = (md == 0) ? "R6" : "R5";
    nexp = (vl > 64) ? 64 : vl;
    for (int k = 0; k < 8; k++) lastuse[k] = -1000;
    @(posedge clk); #1;
    start = 1'b1; mode_in = 2'(md); base_in = b; stride_in = s; vlen_in = 8'(vl);
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0; n = 0; prev = -1;
    ea = exp_addr(md, b, s, 0);
    t = 0; lu = lastuse[ea[2:0]] + LAT; if (lu > t) t = lu;
    if (t >= sf && t <= st) t = st + 1;
    while (n < nexp && cyc < 3000) begin
      stall_in = (cyc >= sf && cyc <= st);
      if (cyc == poke && poke >= 0) begin
        start = 1'b1; base_in = b + 777; mode_in = 2'd2;   // R10 poke
      end else begin
        start = 1'b0; base_in = b; mode_in = 2'(md);
      end
      @(negedge clk);
      if (stall_in) begin
        chk(!addr_valid, "R9 valid during stall", AW'(addr_valid), 0);
        chk(elem_idx == 7'(n), "R9 element held", AW'(elem_idx), AW'(n));
      end else if (cyc == t) begin
        chk(addr_valid, {tt, " issue time"}, AW'(addr_valid), 1);
        chk(addr == ea, (poke >= 0) ? "R10 address" : {at, " address"}, addr, ea);
        chk(bank == ea[2:0], "R4 bank", AW'(bank), AW'(ea[2:0]));
        chk(offset == ea[AW-1:3], "R4 offset", AW'(offset), AW'(ea[AW-1:3]));
        chk(last == (n == nexp - 1), "R8 last flag", AW'(last), AW'(n == nexp - 1));
        lastuse[ea[2:0]] = cyc; prev = cyc; n++;
        if (n < nexp) begin
          ea = exp_addr(md, b, s, n);
          t = prev + 1; lu = lastuse[ea[2:0]] + LAT; if (lu > t) t = lu;
          if (t >= sf && t <= st) t = st + 1;
        end
      end else begin
        chk(!addr_valid, {tt, " early issue"}, AW'(addr_valid), 0);
        chk(conflict, "R5 conflict while waiting", AW'(conflict), 1);
      end
      @(posedge clk); #1;
      cyc++;
    end
    stall_in = 1'b0; start = 1'b0;
    chk(n == nexp, "R7 element count", AW'(n), AW'(nexp));
    @(negedge clk);
    chk(!busy && !addr_valid, "R7 idle after sequence", AW'(busy), 0);
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) idx_tab[k] = AW'((k * 37 + 11) % 101);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!addr_valid, "R11 valid in reset", AW'(addr_valid), 0);
    chk(!busy, "R11 busy in reset", AW'(busy), 0);
    chk(!conflict, "R11 conflict in reset", AW'(conflict), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !conflict, "R11 idle after reset", AW'(busy), 0);

    for (int v = 0; v < 8; v++)
      run_vec(int'(VEC[v][73:72]), VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]), -1, -1, -1);

    // R9 stall window in a unit-stride run
    run_vec(0, 32'd200, 32'd1, 6, 2, 4, -1);
    // R10 start pulse during an active run
    run_vec(1, 32'd9, 32'd3, 8, -1, -1, 3);

    // R7 zero length issues nothing
    @(posedge clk); #1;
    start = 1'b1; mode_in = 2'd0; base_in = 32'd4; vlen_in = 8'd0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!busy && !addr_valid, "R7 zero length", AW'(busy | addr_valid), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule